// File: doc/BRIEF.md
# Hexagonal Cluster Energy-Sum Trigger

This block forms a trigger decision from the total energy deposited in a seven-pixel hexagonal cluster. Its input is a stream of hit broadcasts, at most one per clock. Each broadcast names a pixel and carries one of two payloads. A level broadcast carries a 2-bit discriminator code. An energy broadcast carries an 8-bit energy. A level broadcast at or above a programmable discriminator level makes its pixel a seed. The block then opens a short collection window. During the window it adds the energies reported by the seed pixel and by its six hexagonal neighbours.

When the window closes, the 11-bit sum is compared with a programmable threshold. If the sum reaches the threshold, the block emits a one-cycle trigger. The trigger comes with the seed pixel number and a 127-bit readout mask that selects the seed and every existing neighbour. Seeds that arrive while a window is open wait in a small queue. Seeds that find the queue full are discarded and counted. With a low seed level, the block still triggers on events whose energy is shared among several pixels and would fail a single-pixel cut.

Top module: `hexsum_trigger`

## Requirements
- R1: The 127 pixels tile a hexagon of radius 6 in axial coordinates (q, r), with |q|, |r| and |q+r| all at most 6. Pixels are numbered from 0 row by row, starting with the row r = -6, and in increasing q within a row. The neighbours of a pixel are the existing pixels at hex distance 1, so a corner pixel has 3 neighbours and the centre pixel 63 has 6.
- R2: A broadcast with hit_kind = 0 carries a level code in hit_data[1:0]: 00 means no threshold crossed, and 01, 10 and 11 mean levels 1, 2 and 3. It is a seed when the code is nonzero, the code is at least cfg_seed_level, and hit_pix is at most 126. A cfg_seed_level of 00 acts as 01.
- R3: The collection window is the 8 cycles that follow the cycle in which a seed is accepted. Energy broadcasts (hit_kind = 1, energy in hit_data) outside that window do not add to the sum.
- R4: Inside the window, only energy from the seed pixel or one of its neighbours is added. Each of these pixels contributes at most once per window, and only its first report counts.
- R5: The sum is exact up to the largest possible cluster total, 7 x 255 = 1785, with no wrap.
- R6: In the cycle after the last window cycle, trig_sum and trig_pix show the sum and the seed of that cluster, and they hold until the next cluster completes. trig is high for exactly that one cycle if the sum is greater than or equal to cfg_sum_thr, which is sampled in the last window cycle.
- R7: While trig is high, trig_mask has a 1 exactly at the seed pixel and at its existing neighbours. When trig is low, trig_mask is all zero.
- R8: A seed that arrives while a window is open enters a 4-entry queue. Queued seeds are served in arrival order. The head of the queue is accepted in the last window cycle of the cluster before it, so consecutive windows follow each other with no gap.
- R9: A seed that finds the queue full, and is not relieved by a pop in the same cycle, is dropped. seed_drops then increments and saturates at 255.
- R10: After reset, trig is 0, trig_mask is 0, trig_sum, trig_pix and seed_drops are 0, and no window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | A broadcast is present this cycle |
| hit_kind | input | 1 | 0: level code, 1: energy |
| hit_pix | input | 7 | Pixel number of the broadcast |
| hit_data | input | 8 | Level code in bits 1:0, or energy |
| cfg_seed_level | input | 2 | Lowest level code that seeds a cluster |
| cfg_sum_thr | input | 11 | Cluster sum threshold |
| trig | output | 1 | One-cycle trigger pulse |
| trig_pix | output | 7 | Seed pixel of the last completed cluster |
| trig_sum | output | 11 | Energy sum of the last completed cluster |
| trig_mask | output | 127 | Readout mask of the triggering cluster |
| seed_drops | output | 8 | Saturating count of dropped seeds |

## Verification
A corrupted accumulator or neighbour lookup shows up on trig_sum exactly nine cycles after the seed is accepted. The same fault moves the trigger decision whenever the sum sits near the threshold. A window counter that is off by one moves trig by a cycle, or lets a late neighbour energy into the sum. Damaged queue pointers show up a few clusters later as trig_pix values out of arrival order, or as a seed_drops count that moves without a full queue.

// File: rtl/hexsum_pkg.sv
package hexsum_pkg;
  localparam int HEX_R   = 6;
  localparam int NPIX    = 3 * HEX_R * (HEX_R + 1) + 1;
  localparam int PIX_W   = $clog2(NPIX);
  localparam int E_W     = 8;
  localparam int CLU_N   = 7;
  localparam int SUM_W   = E_W + $clog2(CLU_N);
  localparam int SUM_MAX = CLU_N * ((1 << E_W) - 1);

  typedef logic [PIX_W-1:0] pix_t;
  typedef logic [SUM_W-1:0] sum_t;
  typedef logic [NPIX-1:0]  mask_t;
  typedef struct packed { logic ok; pix_t pix; } nbr_t;

  function automatic int row_len(int r);
    return 2 * HEX_R + 1 - ((r < 0) ? -r : r);
  endfunction

  function automatic int row_first(int r);
    int acc = 0;
    for (int rr = -HEX_R; rr < HEX_R; rr++)
      if (rr < r) acc += row_len(rr);
    return acc;
  endfunction

  function automatic int q_low(int r);
    return (r < 0) ? -HEX_R - r : -HEX_R;
  endfunction

  function automatic int pix_row(int p);
    int row = -HEX_R;
    for (int rr = -HEX_R; rr <= HEX_R; rr++)
      if (p >= row_first(rr)) row = rr;
    return row;
  endfunction

  // slot k: 0 = the pixel itself, 1..6 = the six hexagonal directions
  function automatic nbr_t hex_step(pix_t p, int k);
    int r, q, dq, dr, nq, nr, s;
    nbr_t o;
    r = pix_row(int'(p));
    q = q_low(r) + int'(p) - row_first(r);
    case (k)
      1: begin dq =  1; dr =  0; end
      2: begin dq = -1; dr =  0; end
      3: begin dq =  0; dr =  1; end
      4: begin dq =  0; dr = -1; end
      5: begin dq =  1; dr = -1; end
      6: begin dq = -1; dr =  1; end
      default: begin dq = 0; dr = 0; end
    endcase
    nq = q + dq;
    nr = r + dr;
    s  = nq + nr;
    o.ok  = (nq >= -HEX_R) && (nq <= HEX_R) && (nr >= -HEX_R) && (nr <= HEX_R) &&
            (s >= -HEX_R) && (s <= HEX_R);
    o.pix = o.ok ? pix_t'(row_first(nr) + nq - q_low(nr)) : '0;
    return o;
  endfunction

  function automatic mask_t cluster_mask(pix_t p);
    mask_t m = '0;
    nbr_t  n;
    for (int k = 0; k < CLU_N; k++) begin
      n = hex_step(p, k);
      if (n.ok) m[n.pix] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/hexsum_seed_fifo.sv
module hexsum_seed_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] fill;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty = (fill == '0);
  assign full  = (fill == CW'(DEPTH));
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end

  // R9
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full && !pop));
  // R8
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/hexsum_collector.sv
module hexsum_collector
  import hexsum_pkg::*;
#(
  parameter int WIN_LEN = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [PIX_W-1:0] start_pix,
  input  logic           e_valid,
  input  logic [PIX_W-1:0] e_pix,
  input  logic [E_W-1:0] e_val,
  input  logic [SUM_W-1:0] sum_thr,
  output logic           busy,
  output logic           last,
  output logic           fire,
  output logic [PIX_W-1:0] res_pix,
  output logic [SUM_W-1:0] res_sum
);
  localparam int CNT_W = $clog2(WIN_LEN + 1);

  logic             active;
  logic [CNT_W-1:0] cnt;
  pix_t             seed;
  sum_t             acc, acc_nxt;
  logic [CLU_N-1:0] got, slot_hit;
  logic             add;

  for (genvar k = 0; k < CLU_N; k++) begin : g_slot
    nbr_t nb;
    assign nb          = hex_step(seed, k);
    assign slot_hit[k] = active && e_valid && nb.ok && (nb.pix == e_pix) && !got[k];
  end

  assign add     = |slot_hit;
  assign acc_nxt = acc + (add ? sum_t'(e_val) : '0);
  assign last    = active && (cnt == CNT_W'(WIN_LEN - 1));
  assign busy    = active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cnt     <= '0;
      seed    <= '0;
      acc     <= '0;
      got     <= '0;
      fire    <= 1'b0;
      res_pix <= '0;
      res_sum <= '0;
    end else begin
      fire <= 1'b0;
      if (last) begin
        res_sum <= acc_nxt;
        res_pix <= seed;
        fire    <= (acc_nxt >= sum_thr);
      end
      if (start) begin
        active <= 1'b1;
        cnt    <= '0;
        seed   <= start_pix;
        acc    <= '0;
        got    <= '0;
      end else if (active) begin
        acc <= acc_nxt;
        got <= got | slot_hit;
        cnt <= cnt + CNT_W'(1);
        if (last) active <= 1'b0;
      end
    end
  end

  // R5
  sum_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc <= sum_t'(SUM_MAX));
  // R6
  fire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
  // R3
  window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < CNT_W'(WIN_LEN)));
  // R4
  single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_hit));
  // R8
  start_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!active || last));
endmodule

// File: rtl/hexsum_trigger.sv
module hexsum_trigger
  import hexsum_pkg::*;
#(
  parameter int WIN_LEN = 8,
  parameter int QDEPTH  = 4,
  parameter int DROP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_valid,
  input  logic              hit_kind,
  input  logic [PIX_W-1:0]  hit_pix,
  input  logic [E_W-1:0]    hit_data,
  input  logic [1:0]        cfg_seed_level,
  input  logic [SUM_W-1:0]  cfg_sum_thr,
  output logic              trig,
  output logic [PIX_W-1:0]  trig_pix,
  output logic [SUM_W-1:0]  trig_sum,
  output logic [NPIX-1:0]   trig_mask,
  output logic [DROP_W-1:0] seed_drops
);
  localparam logic [DROP_W-1:0] DROP_MAX = {DROP_W{1'b1}};

  logic [1:0] code, eff_lvl;
  logic seed_in, take, direct, drop_ev;
  logic q_push, q_pop, q_empty, q_full;
  pix_t q_head, start_pix;
  logic col_busy, col_last, col_start;

  assign code    = hit_data[1:0];
  assign eff_lvl = (cfg_seed_level == 2'd0) ? 2'd1 : cfg_seed_level;
  assign seed_in = hit_valid && !hit_kind && (code != 2'd0) && (code >= eff_lvl) &&
                   (int'(hit_pix) < NPIX);

  assign take      = !col_busy || col_last;
  assign direct    = take && q_empty && seed_in;
  assign q_pop     = take && !q_empty;
  assign q_push    = seed_in && !direct && (!q_full || q_pop);
  assign drop_ev   = seed_in && !direct && q_full && !q_pop;
  assign col_start = take && (!q_empty || seed_in);
  assign start_pix = q_empty ? hit_pix : q_head;

  hexsum_seed_fifo #(.DEPTH(QDEPTH), .W(PIX_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(q_push), .din(hit_pix), .pop(q_pop),
    .dout(q_head), .empty(q_empty), .full(q_full)
  );

  hexsum_collector #(.WIN_LEN(WIN_LEN)) u_collect (
    .clk(clk), .rst_n(rst_n), .start(col_start), .start_pix(start_pix),
    .e_valid(hit_valid && hit_kind), .e_pix(hit_pix), .e_val(hit_data),
    .sum_thr(cfg_sum_thr), .busy(col_busy), .last(col_last), .fire(trig),
    .res_pix(trig_pix), .res_sum(trig_sum)
  );

  assign trig_mask = trig ? cluster_mask(trig_pix) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)                            seed_drops <= '0;
    else if (drop_ev && seed_drops != DROP_MAX) seed_drops <= seed_drops + DROP_W'(1);
  end

  // R9
  drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_drops != $past(seed_drops)) |-> $past(drop_ev));
  // R7
  mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> ($countones(trig_mask) >= ((HEX_R > 0) ? 4 : 1) &&
              $countones(trig_mask) <= CLU_N));
  // R6
  trig_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig) |-> $past(col_last));
endmodule

// File: tb/tb_hexsum_trigger.sv
module tb_hexsum_trigger;
  import hexsum_pkg::*;
  localparam int WIN = 8;
  localparam int QD  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic hit_valid = 1'b0, hit_kind = 1'b0;
  logic [PIX_W-1:0] hit_pix = '0;
  logic [E_W-1:0] hit_data = '0;
  logic [1:0] cfg_lvl = 2'd1;
  logic [SUM_W-1:0] cfg_thr = '0;
  logic trig;
  logic [PIX_W-1:0] trig_pix;
  logic [SUM_W-1:0] trig_sum;
  logic [NPIX-1:0] trig_mask;
  logic [7:0] seed_drops;

  hexsum_trigger dut (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_kind(hit_kind),
    .hit_pix(hit_pix), .hit_data(hit_data), .cfg_seed_level(cfg_lvl),
    .cfg_sum_thr(cfg_thr), .trig(trig), .trig_pix(trig_pix), .trig_sum(trig_sum),
    .trig_mask(trig_mask), .seed_drops(seed_drops)
  );

  int checks = 0, errors = 0;
  int bq[NPIX], br[NPIX];

  // reference model state
  bit m_active = 0;
  int m_cnt = 0, m_seed = 0, m_acc = 0, m_drops = 0;
  logic [NPIX-1:0] m_got = '0;
  int mq[$];
  bit exp_done = 0, exp_fire = 0;
  int exp_sum = 0, exp_pix = 0;
  int cap_sum[$], cap_pix[$], cap_fire[$], cap_ones[$];

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int iabs(int x); return (x < 0) ? -x : x; endfunction

  // R1: hex distance at most 1 in bench-built coordinates
  function automatic bit near(int a, int b);
    int dq, dr;
    if (a < 0 || b < 0 || a >= NPIX || b >= NPIX) return 0;
    dq = bq[a] - bq[b];
    dr = br[a] - br[b];
    return (iabs(dq) + iabs(dr) + iabs(dq + dr)) <= 2;
  endfunction

  function automatic logic [NPIX-1:0] emask(int p);
    logic [NPIX-1:0] m = '0;
    for (int i = 0; i < NPIX; i++) m[i] = near(i, p);
    return m;
  endfunction

  task automatic m_start(int p);
    m_active = 1; m_cnt = 0; m_seed = p; m_acc = 0; m_got = '0;
  endtask

  task automatic model_step(bit v, bit kind, int pix, int data);
    bit seed_in, last, take;
    int lvl;
    lvl = (cfg_lvl == 0) ? 1 : int'(cfg_lvl);
    seed_in = v && !kind && (data % 4) != 0 && (data % 4) >= lvl && pix < NPIX;
    last = m_active && (m_cnt == WIN - 1);
    exp_done = 0;
    if (m_active && v && kind && near(pix, m_seed) && !m_got[pix]) begin
      m_acc += data;
      m_got[pix] = 1'b1;
    end
    if (last) begin
      exp_done = 1; exp_sum = m_acc; exp_pix = m_seed; exp_fire = (m_acc >= int'(cfg_thr));
    end
    take = !m_active || last;
    if (m_active) begin
      m_cnt++;
      if (last) m_active = 0;
    end
    if (take) begin
      if (mq.size() > 0) begin
        m_start(mq.pop_front());
        if (seed_in) mq.push_back(pix);
      end else if (seed_in) m_start(pix);
    end else if (seed_in) begin
      if (mq.size() < QD) mq.push_back(pix);
      else if (m_drops < 255) m_drops++;
    end
  endtask

  // called at a negedge: check outputs, advance model, drive next inputs
  task automatic cyc(bit v, bit kind, int pix, int data);
    logic [NPIX-1:0] em;
    chk(trig === (exp_done && exp_fire), "R6 trig", trig, exp_done && exp_fire);
    chk(seed_drops === 8'(m_drops), "R9 drops", seed_drops, m_drops);
    em = (exp_done && exp_fire) ? emask(exp_pix) : '0;
    chk(trig_mask === em, "R7 mask", $countones(trig_mask), $countones(em));
    if (exp_done) begin
      chk(int'(trig_sum) == exp_sum, "R5 sum", trig_sum, exp_sum);
      chk(int'(trig_pix) == exp_pix, "R6 pix", trig_pix, exp_pix);
      cap_sum.push_back(int'(trig_sum));
      cap_pix.push_back(int'(trig_pix));
      cap_fire.push_back(int'(trig));
      cap_ones.push_back($countones(trig_mask));
    end
    model_step(v, kind, pix, data);
    hit_valid = v; hit_kind = kind; hit_pix = PIX_W'(pix); hit_data = E_W'(data);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
  endtask

  function automatic int pick_near(int a);
    int cands[$];
    for (int i = 0; i < NPIX; i++) if (near(i, a)) cands.push_back(i);
    return cands[$urandom_range(0, cands.size() - 1)];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int idx, n0, nb, d0, s;
    s = $urandom(32'd20240611);
    idx = 0;
    for (int r = -HEX_R; r <= HEX_R; r++)
      for (int q = -HEX_R; q <= HEX_R; q++)
        if (iabs(q + r) <= HEX_R) begin bq[idx] = q; br[idx] = r; idx++; end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk(trig === 1'b0 && trig_mask === '0, "R10 trig/mask", trig, 0);
    chk(trig_sum === '0 && trig_pix === '0, "R10 sum/pix", trig_sum, 0);
    chk(seed_drops === '0, "R10 drops", seed_drops, 0);

    // R1 R5: full centre cluster at 255 each
    cfg_lvl = 2'd1; cfg_thr = 11'd1785;
    cyc(1, 0, 63, 1);
    for (int i = 0; i < NPIX; i++) if (near(i, 63)) cyc(1, 1, i, 255);
    idle(12);
    chk(cap_sum[$] == 1785, "R5 max sum", cap_sum[$], 1785);
    chk(cap_fire[$] == 1, "R6 fire at max", cap_fire[$], 1);
    chk(cap_ones[$] == 7, "R1 centre cluster size", cap_ones[$], 7);

    // R1 R4: corner seed, stranger pixel, duplicate report
    cfg_thr = 11'd40;
    cyc(1, 0, 0, 3);
    cyc(1, 1, 30, 200);
    for (int i = 0; i < NPIX; i++) if (near(i, 0)) cyc(1, 1, i, 10);
    cyc(1, 1, 0, 50);
    idle(12);
    chk(cap_sum[$] == 40, "R4 stranger and duplicate ignored", cap_sum[$], 40);
    chk(cap_ones[$] == 4, "R1 corner cluster size", cap_ones[$], 4);

    // R3 R6: window edge and threshold equality
    nb = pick_near(63);
    while (nb == 63) nb = pick_near(63);
    for (int t = 0; t < 2; t++) begin
      cfg_thr = (t == 0) ? 11'd101 : 11'd100;
      cyc(1, 0, 63, 2);
      idle(7);
      cyc(1, 1, 63, 100);
      cyc(1, 1, nb, 100);
      idle(12);
      chk(cap_sum[$] == 100, "R3 late energy excluded", cap_sum[$], 100);
      chk(cap_fire[$] == t, "R6 threshold compare", cap_fire[$], t);
    end

    // R2: seed qualification
    n0 = cap_sum.size();
    cfg_lvl = 2'd1; cyc(1, 0, 63, 0);
    cfg_lvl = 2'd2; cyc(1, 0, 63, 1);
    idle(12);
    chk(cap_sum.size() == n0, "R2 no seed below level", cap_sum.size(), n0);
    cfg_lvl = 2'd0; cyc(1, 0, 63, 1);
    idle(12);
    chk(cap_sum.size() == n0 + 1, "R2 level zero acts as one", cap_sum.size(), n0 + 1);

    // R8 R9: burst of six seeds
    cfg_lvl = 2'd1; cfg_thr = 11'd0;
    n0 = cap_pix.size(); d0 = m_drops;
    for (int i = 1; i <= 6; i++) cyc(1, 0, i * 10, 1);
    idle(60);
    chk(cap_pix.size() == n0 + 5, "R8 queued seeds served", cap_pix.size(), n0 + 5);
    for (int i = 0; i < 5; i++)
      chk(cap_pix[n0 + i] == (i + 1) * 10, "R8 arrival order", cap_pix[n0 + i], (i + 1) * 10);
    chk(int'(seed_drops) == d0 + 1, "R9 one drop", seed_drops, d0 + 1);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int r;
      if (i % 500 == 0) begin
        cfg_thr = 11'($urandom_range(0, SUM_MAX));
        cfg_lvl = 2'($urandom_range(0, 3));
      end
      r = $urandom_range(0, 99);
      if (r < 8) cyc(1, 0, $urandom_range(0, NPIX), $urandom_range(0, 3));
      else if (r < 60) cyc(1, 1, pick_near(m_seed), $urandom_range(0, 255));
      else if (r < 72) cyc(1, 1, $urandom_range(0, NPIX - 1), $urandom_range(0, 255));
      else cyc(0, 0, 0, 0);
    end
    idle(50);

    // R9 saturation
    cfg_lvl = 2'd1;
    for (int i = 0; i < 300; i++) cyc(1, 0, 5, 1);
    idle(60);
    chk(seed_drops === 8'd255, "R9 drop count saturates", seed_drops, 255);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule